// File: doc/BRIEF.md
# Fractional Multiplier with Left Shift

This block multiplies two signed fractional fixed-point operands of `WL` bits. Each operand has no integer bits, so its value lies in [-1, 1). The block forms the complete signed product of `2*WL` bits before it discards any bit. It then returns a `WL`-bit result, read from a window of that product.

A small unsigned shift input moves the window left by `k` positions. With `k` equal to zero the result is the ordinary 1.(WL-1) fractional product. With larger `k`, the result holds the same bits a fractional multiply followed by a logical left shift of `k` would give. The difference is in the low `k` bits: they carry real product bits instead of zeros. Bits that leave the top of the window are lost and nothing clamps the value.

A mode input selects how the bits below the window are handled. In truncate mode they are dropped. In round mode, half a result LSB is added before the cut. A parameter picks either a purely combinational datapath or a single register stage with a valid flag.

Top module: `fml_top`

## Requirements
- R1: With shift 0 and truncate mode (`rnd_i`=0), `res_o` equals floor(a*b / 2^(WL-1)) modulo 2^WL, where a and b are the two's-complement integer values of `opa_i` and `opb_i`. A zero operand gives a zero result.
- R2: With shift k (0 ≤ k ≤ WL-1) in truncate mode, bit i of `res_o` equals bit (i + WL-1-k) of the signed 2·WL-bit product a*b, for every i from 0 to WL-1.
- R3: With `rnd_i`=1, the result is the truncated window of R2 plus product bit (WL-2-k), taken modulo 2^WL (round half up). For k = WL-1 there is no bit below the window, so both modes give the same result.
- R4: The result never saturates. A value outside the window range wraps modulo 2^WL: -1 × -1 (both operands equal to 1 followed by zeros) at shift 0 gives `res_o` = 1 followed by zeros, in both modes. For `opb_i` = -1 at shift 0 in truncate mode, the result is -a modulo 2^WL.
- R5: For WL=8 and k=2, the upper six result bits equal the low six bits of the shift-0 truncated result. The lowest two result bits equal product bits 6 and 5.
- R6: With PIPE=1, `res_o` and `out_vld` update on the first rising clock edge after the inputs are presented. `out_vld` follows `in_vld` with one cycle of delay. While `in_vld` is 0, `res_o` keeps its previous value whatever the other inputs do.
- R7: With PIPE=1, while `rst_n` is low, `out_vld` is 0 and `res_o` is all zeros.
- R8: With PIPE=0, `out_vld` equals `in_vld` and `res_o` follows the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands and controls are valid this cycle |
| opa_i | input | WL | First fractional operand, two's complement 1.(WL-1) |
| opb_i | input | WL | Second fractional operand, two's complement 1.(WL-1) |
| lsh_i | input | $clog2(WL) | Left shift of the result window, unsigned |
| rnd_i | input | 1 | 0: truncate low bits, 1: round half up |
| out_vld | output | 1 | Result valid |
| res_o | output | WL | Fractional result |

## Verification
The bench builds two instances. The first uses WL=16 with the register stage. It covers every shift from 0 to 15 in both modes, the -1 × -1 wrap, the hold behaviour while `in_vld` is low, and reset. The second uses WL=8 without the register stage. This small width brings the 1.7 case with a 2-bit shift within reach, and the bench compares its low bits directly against product bits. It also confirms the zero-latency valid path. Every result is checked against an integer model computed in the bench with arithmetic right shifts of the full product.

// File: rtl/fml_pkg.sv
package fml_pkg;

  typedef enum logic {
    RND_TRUNC  = 1'b0,
    RND_HALFUP = 1'b1
  } rnd_mode_e;

endpackage

// File: rtl/fml_prod.sv
module fml_prod #(
  parameter int WL = 16,
  localparam int PW = 2 * WL
) (
  input  logic [WL-1:0] opa_i,
  input  logic [WL-1:0] opb_i,
  output logic [PW-1:0] prod_o
);

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // sign-extend both operands to full product width, then multiply
  always_comb begin
    a_ext  = {{WL{opa_i[WL-1]}}, opa_i};
    b_ext  = {{WL{opb_i[WL-1]}}, opb_i};
    prod_o = a_ext * b_ext;
  end

endmodule

// File: rtl/fml_window.sv
module fml_window
  import fml_pkg::*;
#(
  parameter int WL = 16,
  localparam int PW = 2 * WL,
  localparam int SW = $clog2(WL)
) (
  input  logic [PW-1:0] prod_i,
  input  logic [SW-1:0] lsh_i,
  input  rnd_mode_e     mode_i,
  output logic [WL-1:0] res_o
);

  logic [PW-1:0] shifted;
  logic [WL-1:0] field;
  logic          guard;
  logic          add_half;

  // moving the product left by k places the wanted field at a fixed spot:
  // just below the redundant sign bit; the bit under it is the round guard
  always_comb begin
    shifted  = prod_i << lsh_i;
    field    = shifted[PW-2 -: WL];
    guard    = shifted[WL-2];
    add_half = (mode_i == RND_HALFUP) && guard;
    res_o    = field + {{(WL-1){1'b0}}, add_half};
  end

endmodule

// File: rtl/fml_stage.sv
module fml_stage #(
  parameter int WL   = 16,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [WL-1:0] res_i,
  output logic          vld_o,
  output logic [WL-1:0] res_o
);

  generate
    if (PIPE) begin : g_reg
      logic          vld_q;
      logic [WL-1:0] res_q;
      logic [WL-1:0] res_d;
      logic          res_en;

      always_comb begin
        res_en = vld_i;
        res_d  = res_en ? res_i : res_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else begin
          vld_q <= vld_i;
          res_q <= res_d;
        end
      end

      assign vld_o = vld_q;
      assign res_o = res_q;
    end else begin : g_comb
      assign vld_o = vld_i;
      assign res_o = res_i;
    end
  endgenerate

endmodule

// File: rtl/fml_top.sv
module fml_top
  import fml_pkg::*;
#(
  parameter int WL   = 16,
  parameter bit PIPE = 1'b1,
  localparam int PW  = 2 * WL,
  localparam int SW  = $clog2(WL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [WL-1:0] opa_i,
  input  logic [WL-1:0] opb_i,
  input  logic [SW-1:0] lsh_i,
  input  logic          rnd_i,
  output logic          out_vld,
  output logic [WL-1:0] res_o
);

  logic [PW-1:0] prod;
  logic [WL-1:0] win;
  rnd_mode_e     mode;

  assign mode = rnd_mode_e'(rnd_i);

  fml_prod #(.WL(WL)) u_prod (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .prod_o(prod)
  );

  fml_window #(.WL(WL)) u_win (
    .prod_i(prod),
    .lsh_i (lsh_i),
    .mode_i(mode),
    .res_o (win)
  );

  fml_stage #(.WL(WL), .PIPE(PIPE)) u_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .vld_i(in_vld),
    .res_i(win),
    .vld_o(out_vld),
    .res_o(res_o)
  );

endmodule

// File: rtl/fml_chk.sv
module fml_chk #(
  parameter int WL   = 16,
  parameter bit PIPE = 1'b1,
  localparam int SW  = $clog2(WL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [WL-1:0] opa_i,
  input logic [WL-1:0] opb_i,
  input logic [SW-1:0] lsh_i,
  input logic          rnd_i,
  input logic          out_vld,
  input logic [WL-1:0] res_o
);

  localparam logic [WL-1:0] MINV = {1'b1, {(WL-1){1'b0}}};

  generate
    if (PIPE) begin : g_seq
      // R6
      vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
      // R6
      vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res_o));
      // R1
      zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (opa_i == '0)) |=> (res_o == '0));
      // R4
      neg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (opb_i == MINV) && (lsh_i == '0) && !rnd_i)
          |=> (res_o == ({WL{1'b0}} - $past(opa_i))));
    end else begin : g_cmb
      // R8
      vld_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == in_vld);
      // R1
      zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_i == '0) |-> (res_o == '0));
      // R4
      neg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opb_i == MINV) && (lsh_i == '0) && !rnd_i)
          |-> (res_o == ({WL{1'b0}} - opa_i)));
      // R1
      zero_opb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opb_i == '0) |-> (res_o == '0));
    end
  endgenerate

endmodule

bind fml_top fml_chk #(.WL(WL), .PIPE(PIPE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .in_vld (in_vld),
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .lsh_i  (lsh_i),
  .rnd_i  (rnd_i),
  .out_vld(out_vld),
  .res_o  (res_o)
);

// File: tb/tb_fml_top.sv
module tb_fml_top;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 16;
  localparam int WB = 8;
  localparam int SA = $clog2(WA);
  localparam int SB = $clog2(WB);

  logic          clk;
  logic          rst_n;
  logic          vld;
  logic [WA-1:0] a16, b16;
  logic [SA-1:0] k16;
  logic [WB-1:0] a8, b8;
  logic [SB-1:0] k8;
  logic          rnd;
  logic          ov16, ov8;
  logic [WA-1:0] r16;
  logic [WB-1:0] r8;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fml_top #(.WL(WA), .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(vld), .opa_i(a16), .opb_i(b16),
    .lsh_i(k16), .rnd_i(rnd), .out_vld(ov16), .res_o(r16)
  );

  fml_top #(.WL(WB), .PIPE(1'b0)) dut8 (
    .clk(clk), .rst_n(rst_n), .in_vld(vld), .opa_i(a8), .opb_i(b8),
    .lsh_i(k8), .rnd_i(rnd), .out_vld(ov8), .res_o(r8)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint sx(longint x, int wl);
    return (x >= (64'sd1 <<< (wl - 1))) ? x - (64'sd1 <<< wl) : x;
  endfunction

  function automatic longint prod(longint a, longint b, int wl);
    return sx(a, wl) * sx(b, wl);
  endfunction

  // expected result from integer arithmetic on the full product
  function automatic longint model(longint a, longint b, int k, bit r, int wl);
    longint p, v, g;
    p = prod(a, b, wl);
    v = p >>> (wl - 1 - k);
    g = (k <= wl - 2) ? ((p >>> (wl - 2 - k)) & 64'sd1) : 64'sd0;
    if (r) v = v + g;
    return v & ((64'sd1 <<< wl) - 1);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // present one operation to both instances; sample after the next rising edge
  task automatic run(longint a, longint b, int k, bit r, string req);
    longint e16, e8;
    @(negedge clk);
    vld = 1'b1;
    a16 = WA'(a); b16 = WA'(b); k16 = SA'(k);
    a8  = WB'(a); b8  = WB'(b); k8  = SB'(k % WB);
    rnd = r;
    #1;
    chk(ov8 == 1'b1, "R8 comb valid", longint'(ov8), 1);
    e8 = model(a & 8'hFF, b & 8'hFF, k % WB, r, WB);
    chk(longint'(r8) == e8, req, longint'(r8), e8);
    @(posedge clk);
    #1;
    e16 = model(a & 16'hFFFF, b & 16'hFFFF, k, r, WA);
    chk(ov16 == 1'b1, "R6 valid after one edge", longint'(ov16), 1);
    chk(longint'(r16) == e16, req, longint'(r16), e16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint held, p8, base;
    void'($urandom(32'h5EED_0F1D));
    rst_n = 1'b0; vld = 1'b0; rnd = 1'b0;
    a16 = '0; b16 = '0; k16 = '0; a8 = '0; b8 = '0; k8 = '0;
    repeat (3) @(posedge clk);
    #1;
    // R7
    chk(ov16 == 1'b0, "R7 reset valid", longint'(ov16), 0);
    chk(r16 == '0, "R7 reset result", longint'(r16), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 zero operands and simple values
    run(0, 16'h1234, 0, 0, "R1 zero operand");
    run(16'h4000, 16'h4000, 0, 0, "R1 half times half");
    run(16'hC000, 16'h4000, 0, 0, "R1 negative product");
    // R4 wrap cases
    run(16'h8000, 16'h8000, 0, 0, "R4 -1x-1 truncate");
    chk(r16 == 16'h8000, "R4 -1x-1 literal", longint'(r16), 16'h8000);
    run(16'h8000, 16'h8000, 0, 1, "R4 -1x-1 round");
    run(16'h3A5C, 16'h8000, 0, 0, "R4 times -1");
    run(16'h7FFF, 16'h7FFF, 5, 0, "R4 shift wraps high bits");
    // R3 last shift: round and truncate agree
    run(16'h1357, 16'h2468, 15, 1, "R3 max shift round");
    chk(r16 == 16'(model(16'h1357, 16'h2468, 15, 0, WA)), "R3 max shift equal",
        longint'(r16), model(16'h1357, 16'h2468, 15, 0, WA));

    // R2 / R3 sweep of every shift in both modes
    for (int k = 0; k < WA; k++) begin
      for (int m = 0; m < 2; m++) begin
        for (int n = 0; n < 20; n++) begin
          run(longint'($urandom & 32'hFFFF), longint'($urandom & 32'hFFFF),
              k, bit'(m), m ? "R3 round sweep" : "R2 truncate sweep");
        end
      end
    end

    // R5 WL=8 with shift 2 versus shift 0
    for (int n = 0; n < 30; n++) begin
      longint x, y;
      x = longint'($urandom & 32'hFF);
      y = longint'($urandom & 32'hFF);
      run(x, y, 0, 0, "R5 base");
      base = longint'(r8);
      run(x, y, 2, 0, "R5 shifted");
      p8 = prod(x, y, WB);
      chk(longint'(r8[7:2]) == (base & 63), "R5 upper bits", longint'(r8[7:2]), base & 63);
      chk(longint'(r8[1:0]) == ((p8 >>> 5) & 3), "R5 low bits from product",
          longint'(r8[1:0]), (p8 >>> 5) & 3);
    end

    // R6 hold while not valid, and valid drop
    run(16'h2222, 16'h3333, 3, 1, "R6 load");
    held = longint'(r16);
    @(negedge clk);
    vld = 1'b0; a16 = 16'h7777; b16 = 16'h5555; k16 = 4'd7; rnd = 1'b0;
    a8 = 8'h11; b8 = 8'h22; k8 = 3'd1;
    #1;
    chk(ov8 == 1'b0, "R8 comb valid low", longint'(ov8), 0);
    repeat (2) @(posedge clk);
    #1;
    chk(ov16 == 1'b0, "R6 valid drops", longint'(ov16), 0);
    chk(longint'(r16) == held, "R6 hold result", longint'(r16), held);

    // R7 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ov16 == 1'b0, "R7 async valid", longint'(ov16), 0);
    chk(r16 == '0, "R7 async result", longint'(r16), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule